// File: doc/BRIEF.md
# Self-Clearing Reset and Flush Controller

This block is the reset-and-flush control register of a USB-style controller core. Software writes one 32-bit control word to ask for one of four actions: a core soft reset, a flush of the receive FIFO, a flush of one transmit FIFO or of all of them, or a reset of the frame number counter. The block turns each request into a control level toward the FIFOs, the core state machines or the frame counter. It clears the request bit by itself once the action is over, so software polls the bit until it reads back as 0. The same word also shows, live, whether the bus master is idle and whether a DMA request is in flight.

Flush timing is counted in ticks of the slower core clock, which arrives here as the `slow_tick` enable. A flush bit stays set for `FLUSH_TICKS` ticks. A frame-counter reset bit stays set for `FRM_HOLD` cycles of `clk`. The soft reset runs as a three-state machine:
- `SR_IDLE`: nothing pending.
- `SR_DRAIN`: the request bit is set and `mst_stop_o` asks the bus master to finish its current data phase. The machine moves on to `SR_RESET` once `mst_idle_i` is seen high.
- `SR_RESET`: `core_srst_o` holds the core in reset and every FIFO is forced into flush. The machine returns to `SR_IDLE` when `srst_done_i` is sampled high.

On that return the machine clears every pending flush and frame bit. It also clears the configuration register `cfg_o`, except for the bits marked in `KEEP_MASK`.

Top module: `core_reset_ctrl`

## Requirements
- R1: After reset, the control word reads `{mst_idle_i, dma_busy_i, 30'b0}`, and all control outputs and `cfg_o` are 0.
- R2: Control word bits 31 and 30 show `mst_idle_i` and `dma_busy_i` live. Bits 29:11, 3 and 1 always read 0, and writes to them have no effect. Bits 31 and 30 cannot be written.
- R3: Writing 1 to bit 5 (transmit flush) while it is clear sets the bit and raises `txf_flush_o` in the next cycle. The bit clears at the clock edge of the 8th `slow_tick` that follows the write; a tick in the write cycle itself is not counted.
- R4: Writing 1 to bit 4 (receive flush) behaves the same way for `rxf_flush_o`, with its own independent timer.
- R5: Bits 10:6 hold the transmit FIFO select, which drives `txf_sel_o`. Code 0 is the non-periodic FIFO, codes 1 to 15 select single FIFOs, and 16 selects all of them. A write to this field is ignored while the transmit flush bit is already set. A write that sets the flush bit from clear loads the new select at the same time.
- R6: Writing 1 to bit 2 sets the frame-reset bit and `frm_clr_o` for exactly 3 cycles of `clk`.
- R7: Writing 1 to bit 0 in `SR_IDLE` sets the bit and enters `SR_DRAIN`, where `mst_stop_o` is high. A clock edge with `mst_idle_i` high moves the machine to `SR_RESET`, where `core_srst_o` is high. A clock edge with `srst_done_i` high in `SR_RESET` clears bit 0 and returns to `SR_IDLE`.
- R8: In `SR_RESET`, `txf_flush_o` and `rxf_flush_o` are high and `txf_sel_o` is 16, whatever the stored bits hold.
- R9: Completion of a soft reset clears the transmit flush, receive flush and frame-reset bits. If a control write arrives in the completion cycle, it does not start a new flush or frame reset.
- R10: Address 1 reads and writes the `CFG_W`-bit configuration register. Completion of a soft reset replaces it with `cfg & KEEP_MASK`, and this takes priority over a write in the same cycle.
- R11: Writing 1 to a request bit that is already set does not restart its timer or state, and writing 0 never clears a request bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 1 | 0 selects the control word, 1 the configuration register |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr` (combinational) |
| slow_tick | input | 1 | One pulse per edge of the slower clock; paces the flush timers |
| mst_idle_i | input | 1 | Bus master idle |
| dma_busy_i | input | 1 | DMA request in progress |
| srst_done_i | input | 1 | Core reports that its soft reset is complete |
| txf_flush_o | output | 1 | Transmit FIFO flush level |
| txf_sel_o | output | 5 | Transmit FIFO to flush |
| rxf_flush_o | output | 1 | Receive FIFO flush level |
| frm_clr_o | output | 1 | Frame number counter reset |
| mst_stop_o | output | 1 | Asks the bus master to stop after its current data phase |
| core_srst_o | output | 1 | Core soft reset level |
| cfg_o | output | CFG_W | Configuration register contents |

## Verification
Every register in this block reaches a port in the cycle after it changes. A timer that runs one tick too long or too short shows up on `txf_flush_o` or `rxf_flush_o`, and on the readback, at exactly one clock edge. A select field that should have been locked changes `txf_sel_o` in the cycle after the write. A soft-reset machine in the wrong state shows at once on `mst_stop_o` or `core_srst_o`, and a wrong completion shows up in `cfg_o` and the flush outputs one cycle later. The bench keeps a behavioural model of these requests and compares every output on every clock, so any such fault is reported in the cycle where it first appears.

// File: rtl/rfc_pkg.sv
package rfc_pkg;
    localparam int REG_W    = 32;
    localparam int B_SRST   = 0;
    localparam int B_FRM    = 2;
    localparam int B_RXF    = 4;
    localparam int B_TXF    = 5;
    localparam int SEL_LO   = 6;
    localparam int SEL_W    = 5;
    localparam int B_DMA    = 30;
    localparam int B_IDLE   = 31;
    localparam logic [SEL_W-1:0] SEL_ALL = 5'd16;

    typedef enum logic [1:0] {
        SR_IDLE  = 2'd0,
        SR_DRAIN = 2'd1,
        SR_RESET = 2'd2
    } srst_state_e;
endpackage

// File: rtl/rfc_hold_timer.sv
module rfc_hold_timer #(
    parameter int LEN = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic tick,
    input  logic abort,
    output logic busy
);
    localparam int CW = $clog2(LEN + 1);
    localparam logic [CW-1:0] LAST = CW'(LEN - 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            busy <= 1'b0;
            cnt  <= '0;
        end else if (abort) begin
            busy <= 1'b0;
            cnt  <= '0;
        end else if (!busy) begin
            busy <= start;
            cnt  <= '0;
        end else if (tick) begin
            if (cnt == LAST) begin
                busy <= 1'b0;
            end
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/rfc_srst_fsm.sv
module rfc_srst_fsm
    import rfc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic req,
    input  logic mst_idle,
    input  logic done_in,
    output logic pend,
    output logic stop,
    output logic core_rst,
    output logic finish
);
    srst_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SR_IDLE:  if (req)      state_d = SR_DRAIN;
            SR_DRAIN: if (mst_idle) state_d = SR_RESET;
            SR_RESET: if (done_in)  state_d = SR_IDLE;
            default:                state_d = SR_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= SR_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        pend     = 1'b0;
        stop     = 1'b0;
        core_rst = 1'b0;
        finish   = 1'b0;
        unique case (state_q)
            SR_IDLE: ;
            SR_DRAIN: begin
                pend = 1'b1;
                stop = 1'b1;
            end
            SR_RESET: begin
                pend     = 1'b1;
                core_rst = 1'b1;
                finish   = done_in;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/core_reset_ctrl.sv
module core_reset_ctrl
    import rfc_pkg::*;
#(
    parameter int               FLUSH_TICKS = 8,
    parameter int               FRM_HOLD    = 3,
    parameter int               CFG_W       = 16,
    parameter logic [CFG_W-1:0] KEEP_MASK   = 16'hF0F0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_wr,
    input  logic             reg_addr,
    input  logic [31:0]      reg_wdata,
    output logic [31:0]      reg_rdata,
    input  logic             slow_tick,
    input  logic             mst_idle_i,
    input  logic             dma_busy_i,
    input  logic             srst_done_i,
    output logic             txf_flush_o,
    output logic [4:0]       txf_sel_o,
    output logic             rxf_flush_o,
    output logic             frm_clr_o,
    output logic             mst_stop_o,
    output logic             core_srst_o,
    output logic [CFG_W-1:0] cfg_o
);
    logic             wr_ctl, wr_cfg;
    logic             tx_busy, rx_busy, frm_busy;
    logic             sr_pend, sr_finish;
    logic [SEL_W-1:0] sel_q;
    logic [CFG_W-1:0] cfg_q;
    logic             unused_wdata;

    assign wr_ctl       = reg_wr & ~reg_addr;
    assign wr_cfg       = reg_wr &  reg_addr;
    assign unused_wdata = ^reg_wdata;

    rfc_srst_fsm u_srst (
        .clk      (clk),
        .rst_n    (rst_n),
        .req      (wr_ctl & reg_wdata[B_SRST]),
        .mst_idle (mst_idle_i),
        .done_in  (srst_done_i),
        .pend     (sr_pend),
        .stop     (mst_stop_o),
        .core_rst (core_srst_o),
        .finish   (sr_finish)
    );

    rfc_hold_timer #(.LEN(FLUSH_TICKS)) u_tx_tmr (
        .clk   (clk),
        .rst_n (rst_n),
        .start (wr_ctl & reg_wdata[B_TXF]),
        .tick  (slow_tick),
        .abort (sr_finish),
        .busy  (tx_busy)
    );

    rfc_hold_timer #(.LEN(FLUSH_TICKS)) u_rx_tmr (
        .clk   (clk),
        .rst_n (rst_n),
        .start (wr_ctl & reg_wdata[B_RXF]),
        .tick  (slow_tick),
        .abort (sr_finish),
        .busy  (rx_busy)
    );

    rfc_hold_timer #(.LEN(FRM_HOLD)) u_frm_tmr (
        .clk   (clk),
        .rst_n (rst_n),
        .start (wr_ctl & reg_wdata[B_FRM]),
        .tick  (1'b1),
        .abort (sr_finish),
        .busy  (frm_busy)
    );

    // Select field is frozen while a transmit flush is pending
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                 sel_q <= '0;
        else if (wr_ctl && !tx_busy) sel_q <= reg_wdata[SEL_LO +: SEL_W];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         cfg_q <= '0;
        else if (sr_finish) cfg_q <= cfg_q & KEEP_MASK;
        else if (wr_cfg)    cfg_q <= reg_wdata[CFG_W-1:0];
    end

    assign txf_flush_o = tx_busy | core_srst_o;
    assign rxf_flush_o = rx_busy | core_srst_o;
    assign txf_sel_o   = core_srst_o ? SEL_ALL : sel_q;
    assign frm_clr_o   = frm_busy;
    assign cfg_o       = cfg_q;

    always_comb begin
        reg_rdata = '0;
        if (reg_addr) begin
            reg_rdata[CFG_W-1:0] = cfg_q;
        end else begin
            reg_rdata[B_IDLE]              = mst_idle_i;
            reg_rdata[B_DMA]               = dma_busy_i;
            reg_rdata[SEL_LO +: SEL_W]     = sel_q;
            reg_rdata[B_TXF]               = tx_busy;
            reg_rdata[B_RXF]               = rx_busy;
            reg_rdata[B_FRM]               = frm_busy;
            reg_rdata[B_SRST]              = sr_pend;
        end
    end
endmodule

// File: rtl/core_reset_ctrl_chk.sv
module core_reset_ctrl_chk #(
    parameter int               CFG_W     = 16,
    parameter logic [CFG_W-1:0] KEEP_MASK = 16'hF0F0
) (
    input logic             clk,
    input logic             rst_n,
    input logic             mst_idle_i,
    input logic             mst_stop_o,
    input logic             core_srst_o,
    input logic             txf_flush_o,
    input logic             rxf_flush_o,
    input logic [4:0]       txf_sel_o,
    input logic             frm_clr_o,
    input logic [CFG_W-1:0] cfg_o
);
    assert_stop_excl_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !(mst_stop_o && core_srst_o));

    assert_reset_after_drain_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(core_srst_o) |-> $past(mst_stop_o && mst_idle_i));

    assert_flush_all_in_reset_R8: assert property (@(posedge clk) disable iff (!rst_n)
        core_srst_o |-> (txf_flush_o && rxf_flush_o && txf_sel_o == 5'd16));

    assert_sel_locked_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (txf_flush_o && !core_srst_o && $past(txf_flush_o && !core_srst_o))
            |-> $stable(txf_sel_o));

    assert_pending_cleared_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(core_srst_o) |-> (!txf_flush_o && !rxf_flush_o && !frm_clr_o));

    assert_cfg_masked_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(core_srst_o) |-> ((cfg_o & ~KEEP_MASK) == '0));
endmodule

bind core_reset_ctrl core_reset_ctrl_chk #(
    .CFG_W     (CFG_W),
    .KEEP_MASK (KEEP_MASK)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .mst_idle_i  (mst_idle_i),
    .mst_stop_o  (mst_stop_o),
    .core_srst_o (core_srst_o),
    .txf_flush_o (txf_flush_o),
    .rxf_flush_o (rxf_flush_o),
    .txf_sel_o   (txf_sel_o),
    .frm_clr_o   (frm_clr_o),
    .cfg_o       (cfg_o)
);

// File: tb/test_core_reset_ctrl.sv
`timescale 1ns/1ps
module test_core_reset_ctrl;
    localparam int       NTICK = 8;
    localparam int       NFRM  = 3;
    localparam bit [15:0] KEEP = 16'hF0F0;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic        reg_addr = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        slow_tick = 1'b0;
    logic        mst_idle_i = 1'b1;
    logic        dma_busy_i = 1'b0;
    logic        srst_done_i = 1'b0;
    logic        txf_flush_o, rxf_flush_o, frm_clr_o, mst_stop_o, core_srst_o;
    logic [4:0]  txf_sel_o;
    logic [15:0] cfg_o;

    int n_vec = 0;
    int n_bad = 0;
    int tick_mode = 0;
    bit done_run = 0;

    core_reset_ctrl i_core_reset_ctrl (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .slow_tick(slow_tick),
        .mst_idle_i(mst_idle_i), .dma_busy_i(dma_busy_i), .srst_done_i(srst_done_i),
        .txf_flush_o(txf_flush_o), .txf_sel_o(txf_sel_o), .rxf_flush_o(rxf_flush_o),
        .frm_clr_o(frm_clr_o), .mst_stop_o(mst_stop_o), .core_srst_o(core_srst_o),
        .cfg_o(cfg_o)
    );

    always #4 clk = ~clk;

    // Behavioural reference
    int m_tx = 0, m_txn = 0, m_rx = 0, m_rxn = 0, m_frm = 0, m_frmn = 0;
    int m_sel = 0, m_sr = 0;
    int unsigned m_cfg = 0;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_tx = 0; m_rx = 0; m_frm = 0; m_sel = 0; m_sr = 0; m_cfg = 0;
            m_txn = 0; m_rxn = 0; m_frmn = 0;
        end else begin
            bit wc, wg, fin;
            wc  = reg_wr && !reg_addr;
            wg  = reg_wr && reg_addr;
            fin = (m_sr == 2) && srst_done_i;
            if (wc && m_tx == 0) m_sel = int'(reg_wdata[10:6]);
            if (fin) begin
                m_tx = 0; m_rx = 0; m_frm = 0; m_sr = 0;
                m_cfg = m_cfg & KEEP;
            end else begin
                if (m_sr == 0 && wc && reg_wdata[0]) m_sr = 1;
                else if (m_sr == 1 && mst_idle_i) m_sr = 2;
                if (m_tx != 0) begin
                    if (slow_tick) begin m_txn++; if (m_txn == NTICK) m_tx = 0; end
                end else if (wc && reg_wdata[5]) begin m_tx = 1; m_txn = 0; end
                if (m_rx != 0) begin
                    if (slow_tick) begin m_rxn++; if (m_rxn == NTICK) m_rx = 0; end
                end else if (wc && reg_wdata[4]) begin m_rx = 1; m_rxn = 0; end
                if (m_frm != 0) begin
                    m_frmn++; if (m_frmn == NFRM) m_frm = 0;
                end else if (wc && reg_wdata[2]) begin m_frm = 1; m_frmn = 0; end
                if (wg) m_cfg = int'(reg_wdata[15:0]);
            end
        end
    end

    task automatic check(input string tag, input longint got, input longint exp);
        n_vec++;
        if (got != exp) begin
            n_bad++;
            $display("FAIL %s at %0t: actual %0h expected %0h", tag, $time, got, exp);
        end
    endtask

    always @(negedge clk) begin
        logic [31:0] exp_rd;
        bit in_rst;
        in_rst = (m_sr == 2);
        if (reg_addr) exp_rd = {16'h0, m_cfg[15:0]};
        else exp_rd = {mst_idle_i, dma_busy_i, 19'h0, 5'(m_sel), m_tx[0], m_rx[0],
                       1'b0, m_frm[0], 1'b0, (m_sr != 0)};
        check(rst_n ? "R2/R11 readback" : "R1 reset readback", reg_rdata, exp_rd);
        check("R3/R8/R9 txf_flush", txf_flush_o, (m_tx != 0) || in_rst);
        check("R4/R8/R9 rxf_flush", rxf_flush_o, (m_rx != 0) || in_rst);
        check("R5/R8 txf_sel", txf_sel_o, in_rst ? 16 : m_sel);
        check("R6/R9 frm_clr", frm_clr_o, m_frm != 0);
        check("R7 mst_stop", mst_stop_o, m_sr == 1);
        check("R7 core_srst", core_srst_o, in_rst);
        check("R10 cfg", cfg_o, m_cfg);
    end

    always @(posedge clk) begin
        #1;
        case (tick_mode)
            0: slow_tick <= 1'b1;
            1: slow_tick <= ~slow_tick;
            default: slow_tick <= ($urandom_range(0, 2) == 0);
        endcase
    end

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk); #1;
            reg_wr = 1'b0;
        end
    endtask

    task automatic wr(input bit a, input logic [31:0] d);
        @(posedge clk); #1;
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(posedge clk); #1;
        reg_wr = 1'b0; reg_addr = 1'b0;
    endtask

    initial begin
        idle(3);
        rst_n = 1'b1;
        idle(2);
        // R2 reserved bits, R3 flush of FIFO 3 with half-rate ticks
        wr(0, 32'hFFFF_F80A);
        tick_mode = 1;
        wr(0, (32'd3 << 6) | 32'h20);
        idle(3);
        wr(0, (32'd9 << 6) | 32'h20);   // R5 ignored, R11 no restart
        wr(0, 32'h0);                   // R11 zero write
        idle(20);
        // R5 all-FIFO code, R4 receive flush together
        tick_mode = 0;
        wr(0, (32'd16 << 6) | 32'h30);
        idle(12);
        // R6 frame reset, repeated write while pending
        wr(0, 32'h4);
        wr(0, 32'h4);
        idle(5);
        // R10 cfg, then R7/R8/R9 soft reset during flushes with a busy master
        wr(1, 32'h0000_ABCD);
        mst_idle_i = 1'b0; dma_busy_i = 1'b1;
        tick_mode = 1;
        wr(0, 32'h35);
        idle(4);
        mst_idle_i = 1'b1; dma_busy_i = 1'b0;
        idle(3);
        wr(0, 32'h1);                   // R11 repeat while pending
        srst_done_i = 1'b1;
        reg_wr = 1'b1; reg_addr = 1'b1; reg_wdata = 32'h1234;  // completes same cycle
        idle(1);
        srst_done_i = 1'b0;
        idle(4);
        // R9 write in completion cycle is dropped
        wr(0, 32'h1);
        idle(2);
        @(posedge clk); #1;
        srst_done_i = 1'b1; reg_wr = 1'b1; reg_addr = 1'b0; reg_wdata = 32'h34;
        idle(1);
        srst_done_i = 1'b0;
        idle(5);
        // Random phase
        tick_mode = 2;
        for (int i = 0; i < 3000; i++) begin
            @(posedge clk); #1;
            reg_wr      = ($urandom_range(0, 5) == 0);
            reg_addr    = ($urandom_range(0, 3) == 0);
            reg_wdata   = $urandom;
            if ($urandom_range(0, 7) != 0) reg_wdata[0] = 1'b0;
            mst_idle_i  = ($urandom_range(0, 3) != 0);
            dma_busy_i  = $urandom_range(0, 1);
            srst_done_i = ($urandom_range(0, 4) == 0);
        end
        idle(4);
        done_run = 1;
    end

    initial begin
        int cyc = 0;
        while (!done_run && cyc < 200000) begin
            @(posedge clk);
            cyc++;
        end
        if (!done_run) begin
            n_vec++; n_bad++;
            $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
        end
        $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule